// File: doc/BRIEF.md
# Shared Memory Port Fetch Arbiter

This block sits at the single memory port of a five-stage in-order pipeline, where instruction fetch and data loads and stores both need that one port. Each cycle it looks at the instruction in the memory stage. If that instruction is a load or a store, the data access gets the port. The fetch due in that cycle is dropped, and the bubble travels into decode. If no load or store is present, the fetch gets the port and reads the word at the program counter.

The block holds the program counter, the fetch/decode instruction register with its valid bit, the load-result register of the memory stage, and a stall counter. The memory answers in the same cycle it is addressed. When a fetch stalls, the program counter and the instruction register keep their values and decode is shown a no-op word. The stall counter lets a run confirm that total cycles equal instructions fetched plus port conflicts.

Top module: `memport_arb`

## Requirements
- R1: After reset the program counter equals RESET_PC, the decode valid bit is 0, the load-result register is 0 and the stall counter is 0.
- R2: In a cycle where mem_rd or mem_wr is high, port_addr equals mem_addr. Otherwise port_addr equals the program counter.
- R3: fetch_stall is high exactly when fetch_en is high and mem_rd or mem_wr is high in the same cycle.
- R4: After a stalled cycle the program counter and the held instruction word are unchanged and dec_valid is 0. While dec_valid is 0, dec_instr shows NOP_WORD.
- R5: After a cycle where fetch_en is high and no data access is present, dec_valid is 1, dec_instr equals port_rdata from that cycle, and the program counter has advanced by PC_STEP, modulo 2^AW.
- R6: After a cycle where mem_rd is high and mem_wr is low, mem_result equals port_rdata from that cycle. In every other cycle mem_result holds its value.
- R7: port_we is high only in cycles where mem_wr is high, and it follows mem_wr in every cycle. In those cycles port_wdata equals mem_wdata. When mem_rd and mem_wr are both high, the access is a store.
- R8: stall_count increases by one after each stalled cycle and otherwise holds. With SAT_CNT=1 it stops at its all-ones value.
- R9: In a cycle where fetch_en is low, nothing is fetched. The program counter holds, dec_valid is 0 next cycle, and a data access in that cycle raises no stall.
- R10: For any sequence run with fetch_en high, the number of cycles equals the number of instructions fetched plus the increase in stall_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_en | input | 1 | Fetch requested in this cycle |
| mem_rd | input | 1 | Memory-stage instruction is a load |
| mem_wr | input | 1 | Memory-stage instruction is a store |
| mem_addr | input | AW | Data access address |
| mem_wdata | input | DW | Store data |
| port_rdata | input | DW | Read data returned by the shared port in the same cycle |
| port_addr | output | AW | Address driven to the shared port |
| port_we | output | 1 | Write enable to the shared port |
| port_wdata | output | DW | Write data to the shared port |
| fetch_stall | output | 1 | Fetch lost the port this cycle |
| pc | output | AW | Program counter |
| dec_instr | output | DW | Instruction shown to decode (NOP_WORD when invalid) |
| dec_valid | output | 1 | Decode holds a real instruction |
| mem_result | output | DW | Memory-stage load result register |
| stall_count | output | CW | Count of fetch bubbles |

## Verification
Properties are evaluated on every cycle for the following:
- the data side always owns the address and write path;
- a stalled cycle freezes the program counter and the instruction word and clears valid;
- an unstalled fetch advances by one step;
- a load captures the port data;
- the counter steps once per bubble.

Some behaviours only the bench scenarios can show:
- a store followed by a load reading back the stored word;
- fetches returning the right memory contents at the right addresses;
- counter saturation;
- cycle accounting over a whole instruction run, where cycles equal fetches plus conflicts.

These are checked against a behavioural model of the pipeline front end.

// File: rtl/memport_pkg.sv
package memport_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE  = 2'd0,
      OWN_FETCH = 2'd1,
      OWN_DATA  = 2'd2
   } port_owner_e;
endpackage

// File: rtl/memport_mux.sv
module memport_mux
   import memport_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          fetch_en,
   input  logic          mem_rd,
   input  logic          mem_wr,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_wdata,
   input  logic [AW-1:0] pc,
   output port_owner_e   owner,
   output logic [AW-1:0] port_addr,
   output logic          port_we,
   output logic [DW-1:0] port_wdata
);
   always_comb begin
      if (mem_rd || mem_wr)  owner = OWN_DATA;
      else if (fetch_en)     owner = OWN_FETCH;
      else                   owner = OWN_IDLE;
   end

   assign port_addr  = (owner == OWN_DATA) ? mem_addr : pc;
   assign port_we    = (owner == OWN_DATA) && mem_wr;
   assign port_wdata = mem_wdata;
endmodule

// File: rtl/memport_fetch.sv
module memport_fetch
   import memport_pkg::*;
#(
   parameter int          AW       = 16,
   parameter int          DW       = 32,
   parameter int          PC_STEP  = 4,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_en,
   input  port_owner_e   owner,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] ifid_instr,
   output logic          ifid_valid,
   output logic          stall
);
   localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

   logic take;
   assign take  = (owner == OWN_FETCH);
   assign stall = fetch_en && (owner == OWN_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc         <= RESET_PC;
         ifid_instr <= '0;
         ifid_valid <= 1'b0;
      end else begin
         ifid_valid <= take;
         if (take) begin
            pc         <= pc + STEP_V;
            ifid_instr <= rdata;
         end
      end
   end

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(pc) && $stable(ifid_instr) && !ifid_valid));

   // R5
   fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en && !stall) |=> (ifid_valid && pc == AW'($past(pc) + STEP_V)));

   // R9
   no_fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_en |=> ($stable(pc) && !ifid_valid));
endmodule

// File: rtl/memport_stallcnt.sv
module memport_stallcnt #(
   parameter int CW      = 16,
   parameter bit SAT_CNT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] ONE = CW'(1);

   generate
      if (SAT_CNT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (inc && cnt != '1)   cnt <= cnt + ONE;
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt <= '0;
            else if (inc) cnt <= cnt + ONE;
         end
      end
   endgenerate

   // R8
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && (cnt != '1)) |=> (cnt == CW'($past(cnt) + ONE)));

   // R8
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt));
endmodule

// File: rtl/memport_arb.sv
module memport_arb
   import memport_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 32,
   parameter int            CW       = 16,
   parameter int            PC_STEP  = 4,
   parameter logic [AW-1:0] RESET_PC = '0,
   parameter logic [DW-1:0] NOP_WORD = '0,
   parameter bit            SAT_CNT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_en,
   input  logic          mem_rd,
   input  logic          mem_wr,
   input  logic [AW-1:0] mem_addr,
   input  logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] port_rdata,
   output logic [AW-1:0] port_addr,
   output logic          port_we,
   output logic [DW-1:0] port_wdata,
   output logic          fetch_stall,
   output logic [AW-1:0] pc,
   output logic [DW-1:0] dec_instr,
   output logic          dec_valid,
   output logic [DW-1:0] mem_result,
   output logic [CW-1:0] stall_count
);
   generate
      if (AW < 4 || AW > 64) begin : g_bad_aw
         $error("memport_arb: AW out of range");
      end
      if (DW < 8) begin : g_bad_dw
         $error("memport_arb: DW too small");
      end
      if (CW < 2) begin : g_bad_cw
         $error("memport_arb: CW too small");
      end
      if (PC_STEP < 1) begin : g_bad_step
         $error("memport_arb: PC_STEP must be positive");
      end
   endgenerate

   port_owner_e   owner;
   logic [DW-1:0] ifid_instr;
   logic          load_cap;

   memport_mux #(.AW(AW), .DW(DW)) u_mux (
      .fetch_en   (fetch_en),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .pc         (pc),
      .owner      (owner),
      .port_addr  (port_addr),
      .port_we    (port_we),
      .port_wdata (port_wdata)
   );

   memport_fetch #(.AW(AW), .DW(DW), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fetch_en   (fetch_en),
      .owner      (owner),
      .rdata      (port_rdata),
      .pc         (pc),
      .ifid_instr (ifid_instr),
      .ifid_valid (dec_valid),
      .stall      (fetch_stall)
   );

   memport_stallcnt #(.CW(CW), .SAT_CNT(SAT_CNT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fetch_stall),
      .cnt   (stall_count)
   );

   assign dec_instr = dec_valid ? ifid_instr : NOP_WORD;
   assign load_cap  = mem_rd && !mem_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem_result <= '0;
      else if (load_cap) mem_result <= port_rdata;
   end

   // R2
   data_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (port_addr == mem_addr));

   // R7
   we_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |-> (mem_wr && port_addr == mem_addr && port_wdata == mem_wdata));

   // R6
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_wr) |=> (mem_result == $past(port_rdata)));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && !mem_wr) |=> $stable(mem_result));

   // R3
   stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> (fetch_en && port_addr == mem_addr));
endmodule

// File: tb/test_memport_arb.sv
`timescale 1ns/1ps
module test_memport_arb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam logic [DW-1:0] NOP = 32'h0000_0013;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_en = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [DW-1:0] mem_wdata = '0;
   logic [DW-1:0] port_rdata;
   logic [AW-1:0] port_addr, pc;
   logic          port_we, fetch_stall, dec_valid;
   logic [DW-1:0] port_wdata, dec_instr, mem_result;
   logic [CW-1:0] stall_count;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   memport_arb #(.AW(AW), .DW(DW), .CW(CW), .PC_STEP(4), .RESET_PC('0),
                 .NOP_WORD(NOP), .SAT_CNT(1'b1)) i_memport_arb (
      .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .port_rdata(port_rdata),
      .port_addr(port_addr), .port_we(port_we), .port_wdata(port_wdata),
      .fetch_stall(fetch_stall), .pc(pc), .dec_instr(dec_instr), .dec_valid(dec_valid),
      .mem_result(mem_result), .stall_count(stall_count)
   );

   // memory attached to the port
   logic [DW-1:0] mem [256];
   assign port_rdata = mem[port_addr[9:2]];
   always @(posedge clk) if (port_we) mem[port_addr[9:2]] <= port_wdata;

   // behavioural reference state
   logic [DW-1:0] refmem [256];
   logic [AW-1:0] m_pc;
   logic [DW-1:0] m_instr, m_res;
   logic          m_valid;
   int            m_cnt;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_state();
      chk("R4/R5 pc", 64'(pc), 64'(m_pc));
      chk("R4/R5/R9 dec_valid", 64'(dec_valid), 64'(m_valid));
      chk("R4/R5 dec_instr", 64'(dec_instr), 64'(m_valid ? m_instr : NOP));
      chk("R6 mem_result", 64'(mem_result), 64'(m_res));
      chk("R8 stall_count", 64'(stall_count), 64'(m_cnt));
   endtask

   // one cycle: drive at negedge, check combinational outputs, model the edge, check state
   task automatic step(input logic fe, input logic rd, input logic wr,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
      logic gnt;
      fetch_en = fe; mem_rd = rd; mem_wr = wr; mem_addr = a; mem_wdata = wd;
      #1;
      gnt = rd | wr;
      chk("R2 port_addr", 64'(port_addr), 64'(gnt ? a : m_pc));
      chk("R3 fetch_stall", 64'(fetch_stall), 64'(fe & gnt));
      chk("R7 port_we", 64'(port_we), 64'(wr));
      if (wr) chk("R7 port_wdata", 64'(port_wdata), 64'(wd));
      if (wr) refmem[a[9:2]] = wd;
      else if (rd) m_res = refmem[a[9:2]];
      if (fe && !gnt) begin
         m_instr = refmem[m_pc[9:2]];
         m_valid = 1'b1;
         m_pc    = m_pc + AW'(4);
      end else begin
         m_valid = 1'b0;
      end
      if (fe && gnt && m_cnt < 15) m_cnt++;
      @(negedge clk);
      check_state();
   endtask

   initial begin
      #(4ns * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cyc, fetched, c0;
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 32'hA500_0000 ^ (i * 32'h0101_0101);
         refmem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
      end
      m_pc = '0; m_instr = '0; m_res = '0; m_valid = 1'b0; m_cnt = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check_state();
      rst_n = 1'b1;
      @(negedge clk);
      check_state();

      // R5 plain fetch run
      for (int i = 0; i < 5; i++) step(1, 0, 0, '0, '0);
      // R3 R4 R6 fetch interleaved with loads
      step(1, 1, 0, 16'h0100, '0);
      step(1, 0, 0, '0, '0);
      step(1, 1, 0, 16'h0104, '0);
      step(1, 1, 0, 16'h0108, '0);
      step(1, 0, 0, '0, '0);
      // R7 store then load back; R6 store leaves result alone
      step(1, 0, 1, 16'h0200, 32'hDEAD_BEEF);
      step(1, 1, 0, 16'h0200, '0);
      // R7 rd and wr together act as a store
      step(1, 1, 1, 16'h0204, 32'h1234_5678);
      step(0, 1, 0, 16'h0204, '0);
      // R9 no fetch requested: no stall, pc holds
      step(0, 0, 0, '0, '0);
      step(0, 1, 0, 16'h0100, '0);
      step(1, 0, 0, '0, '0);

      // R10 cycle accounting over a run
      c0 = int'(stall_count); cyc = 0; fetched = 0;
      for (int i = 0; i < 12; i++) begin
         step(1, (i % 3 == 0), 0, AW'(16'h0300 + 4 * i), '0);
         cyc++;
         if (dec_valid) fetched++;
      end
      chk("R10 cycles=fetched+stalls", 64'(cyc), 64'(fetched + int'(stall_count) - c0));

      // R8 saturation
      for (int i = 0; i < 16; i++) step(1, 1, 0, AW'(4 * i), '0);
      chk("R8 saturated count", 64'(stall_count), 64'(15));

      // R1 reset again mid-run
      rst_n = 1'b0; #1;
      m_pc = '0; m_res = '0; m_valid = 1'b0; m_cnt = 0;
      check_state();
      @(negedge clk); rst_n = 1'b1;
      step(1, 0, 0, '0, '0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule